// File: doc/BRIEF.md
# Eight-Slot Serial Audio Frame Receiver

This block receives a time-multiplexed serial audio stream as a slave. It runs on the incoming bit clock and watches two inputs: a frame-sync line and one serial data line. A frame starts when the frame-sync line goes from low to high. The first data bit comes on the bit-clock edge right after the edge that saw that rise. Eight words then follow with no gaps between them. The block writes them into eight parallel channel registers, which hold four stereo pairs.

The input word length is set by a two-bit code. Each word is left-justified into a 32-bit channel register, and any unused low bits are filled with zeros. Nothing updates the visible channel registers until the whole frame has been captured. All eight then change on the same edge, and a frame-valid strobe pulses for one cycle. If a new frame-sync rise arrives before the frame is complete, the block drops the partial frame, pulses a frame-error flag and starts capturing the new frame.

Top module: `dsp_tdm_rx`

## Requirements
- R1: A frame-sync rise is a rising bit-clock edge at which `fsync_i` is 1 after it was 0 at the previous edge. The MSB of slot 0 is sampled on the next rising edge after that one.
- R2: `wlen_i` sets the word length: 0 gives 16 bits, 1 gives 20, 2 gives 24 and 3 gives 32. Each word arrives MSB first.
- R3: Slot k lands in `ch_o[32k+31:32k]`. The slot order is: k=0 channel 1 left, k=1 channel 1 right, k=2 channel 2 left, k=3 channel 2 right, and so on up to k=7 channel 4 right.
- R4: The words follow each other with no gaps. The MSB of slot k+1 is sampled on the edge right after the LSB of slot k.
- R5: A word shorter than 32 bits sits in the upper bits of its register, and the bits below it read as 0.
- R6: Once the LSB of slot 7 is sampled, all eight registers update on that same edge and `frame_valid_o` is 1 for exactly the following cycle. At any other time `ch_o` holds its value.
- R7: After slot 7, any further bits are ignored until the next frame-sync rise. They produce no strobe and no change on `ch_o`.
- R8: If a frame-sync rise arrives before slot 7 is complete, `frame_err_o` is 1 for the one cycle after that edge. The partial frame never reaches `ch_o`, and capture restarts at slot 0 with the new frame.
- R9: While `rst_ni` is low, `ch_o` reads 0 and both strobes are 0. A frame-sync line that is already high when reset releases does not start a frame.
- R10: If the frame-sync line stays high for several cycles, only its rise counts. The cycles it stays high do not restart the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock, rising edge samples |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wlen_i | input | 2 | Word-length code |
| fsync_i | input | 1 | Frame-sync line |
| sdata_i | input | 1 | Serial data |
| ch_o | output | 256 | Eight channel registers, slot k at bits 32k+31:32k |
| frame_valid_o | output | 1 | One-cycle pulse when a new frame is on `ch_o` |
| frame_err_o | output | 1 | One-cycle pulse when a frame-sync rise cuts a frame short |

## Verification
The bench sends whole frames at every word length and checks each slot value. A design that samples the MSB one edge early or late, or leaves a gap between words, shifts every word and fails these checks, as does one that mixes up slot order or skips the zero fill. It sends frames with a frame-sync pulse that stays high for many cycles, with junk bits after slot 7, and with a frame-sync line held high as reset releases. A design that treats the frame-sync level as a start would restart the frame or begin a false frame in these cases. Last, a frame cut short by an early frame-sync rise must leave the previous frame on `ch_o`, raise the error pulse one cycle after the rise, and still capture the next frame correctly.

// File: rtl/dsp_rx_pkg.sv
package dsp_rx_pkg;
  localparam int NUM_SLOTS_D = 8;
  localparam int DATA_W_D    = 32;

  typedef enum logic [1:0] {
    WL_16 = 2'd0,
    WL_20 = 2'd1,
    WL_24 = 2'd2,
    WL_32 = 2'd3
  } wlen_e;

  function automatic logic [5:0] wlen_bits(wlen_e w);
    case (w)
      WL_16:   return 6'd16;
      WL_20:   return 6'd20;
      WL_24:   return 6'd24;
      default: return 6'd32;
    endcase
  endfunction
endpackage

// File: rtl/dsp_rx_fsync_det.sv
module dsp_rx_fsync_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fsync_i,
  output logic rise_o
);
  logic fs_q;

  // Reset to 1: a line already high at reset release is not a rise.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fs_q <= 1'b1;
    else         fs_q <= fsync_i;
  end

  assign rise_o = fsync_i & ~fs_q;
endmodule

// File: rtl/dsp_rx_slot_seq.sv
module dsp_rx_slot_seq #(
  parameter int NUM_SLOTS = 8,
  parameter int SLOT_W    = 3,
  parameter int CNT_W     = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rise_i,
  input  logic [CNT_W-1:0]  wbits_i,
  output logic              sample_o,
  output logic              word_done_o,
  output logic              frame_done_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              frame_err_o
);
  logic              active_q;
  logic [CNT_W-1:0]  bit_q;
  logic [SLOT_W-1:0] slot_q;
  logic              err_q;
  logic              last_bit;
  logic              last_slot;

  assign sample_o     = active_q & ~rise_i;
  assign last_bit     = (bit_q == wbits_i - CNT_W'(1));
  assign last_slot    = (slot_q == SLOT_W'(NUM_SLOTS - 1));
  assign word_done_o  = sample_o & last_bit;
  assign frame_done_o = word_done_o & last_slot;
  assign slot_o       = slot_q;
  assign frame_err_o  = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      bit_q    <= '0;
      slot_q   <= '0;
      err_q    <= 1'b0;
    end else begin
      err_q <= rise_i & active_q;
      if (rise_i) begin
        active_q <= 1'b1;
        bit_q    <= '0;
        slot_q   <= '0;
      end else if (active_q) begin
        if (last_bit) begin
          bit_q <= '0;
          if (last_slot) active_q <= 1'b0;
          else           slot_q   <= slot_q + SLOT_W'(1);
        end else begin
          bit_q <= bit_q + CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/dsp_rx_shifter.sv
module dsp_rx_shifter #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sample_i,
  input  logic              sdata_i,
  input  logic [CNT_W-1:0]  wbits_i,
  output logic [DATA_W-1:0] word_o
);
  logic [DATA_W-1:0] sh_q;
  logic [DATA_W-1:0] sh_next;
  logic [CNT_W-1:0]  shamt;

  assign sh_next = {sh_q[DATA_W-2:0], sdata_i};
  assign shamt   = CNT_W'(DATA_W) - wbits_i;
  // Stale upper bits fall off the top; the low bits are zero-filled.
  assign word_o  = sh_next << shamt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sh_q <= '0;
    else if (sample_i) sh_q <= sh_next;
  end
endmodule

// File: rtl/dsp_rx_slot_bank.sv
module dsp_rx_slot_bank #(
  parameter int NUM_SLOTS = 8,
  parameter int DATA_W    = 32,
  parameter int SLOT_W    = 3
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        word_done_i,
  input  logic                        frame_done_i,
  input  logic [SLOT_W-1:0]           slot_i,
  input  logic [DATA_W-1:0]           word_i,
  output logic [NUM_SLOTS*DATA_W-1:0] ch_o,
  output logic                        valid_o
);
  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
    logic [DATA_W-1:0] out_q;
    logic [DATA_W-1:0] src;

    if (k == NUM_SLOTS - 1) begin : g_last
      assign src = word_i;
    end else begin : g_stage
      logic [DATA_W-1:0] stage_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q <= '0;
        else if (word_done_i && slot_i == SLOT_W'(k)) stage_q <= word_i;
      end
      assign src = stage_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           out_q <= '0;
      else if (frame_done_i) out_q <= src;
    end

    assign ch_o[k*DATA_W +: DATA_W] = out_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_o <= 1'b0;
    else         valid_o <= frame_done_i;
  end
endmodule

// File: rtl/dsp_tdm_rx.sv
module dsp_tdm_rx
  import dsp_rx_pkg::*;
#(
  parameter int NUM_SLOTS = NUM_SLOTS_D,
  parameter int DATA_W    = DATA_W_D
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [1:0]                  wlen_i,
  input  logic                        fsync_i,
  input  logic                        sdata_i,
  output logic [NUM_SLOTS*DATA_W-1:0] ch_o,
  output logic                        frame_valid_o,
  output logic                        frame_err_o
);
  localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
  localparam int CNT_W  = $clog2(DATA_W + 1);

  logic              rise;
  logic              sample;
  logic              word_done;
  logic              frame_done;
  logic [SLOT_W-1:0] slot;
  logic [CNT_W-1:0]  wbits;
  logic [DATA_W-1:0] word;

  assign wbits = CNT_W'(wlen_bits(wlen_e'(wlen_i)));

  dsp_rx_fsync_det u_det (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fsync_i (fsync_i),
    .rise_o  (rise)
  );

  dsp_rx_slot_seq #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W), .CNT_W(CNT_W)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rise_i       (rise),
    .wbits_i      (wbits),
    .sample_o     (sample),
    .word_done_o  (word_done),
    .frame_done_o (frame_done),
    .slot_o       (slot),
    .frame_err_o  (frame_err_o)
  );

  dsp_rx_shifter #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_sh (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sample_i (sample),
    .sdata_i  (sdata_i),
    .wbits_i  (wbits),
    .word_o   (word)
  );

  dsp_rx_slot_bank #(.NUM_SLOTS(NUM_SLOTS), .DATA_W(DATA_W), .SLOT_W(SLOT_W)) u_bank (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .word_done_i  (word_done),
    .frame_done_i (frame_done),
    .slot_i       (slot),
    .word_i       (word),
    .ch_o         (ch_o),
    .valid_o      (frame_valid_o)
  );
endmodule

// File: rtl/dsp_tdm_rx_chk.sv
module dsp_tdm_rx_chk
  import dsp_rx_pkg::*;
#(
  parameter int NUM_SLOTS = NUM_SLOTS_D,
  parameter int DATA_W    = DATA_W_D
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic [1:0]                  wlen_i,
  input logic                        fsync_i,
  input logic [NUM_SLOTS*DATA_W-1:0] ch_o,
  input logic                        frame_valid_o,
  input logic                        frame_err_o
);
  logic [1:0]           wl_q;
  logic [DATA_W-1:0]    low_mask;
  logic [NUM_SLOTS-1:0] low_bad;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wl_q <= 2'd3;
    else         wl_q <= wlen_i;
  end

  assign low_mask = ~({DATA_W{1'b1}} << (DATA_W - int'(wlen_bits(wlen_e'(wl_q)))));

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_low
    assign low_bad[k] = |(ch_o[k*DATA_W +: DATA_W] & low_mask);
  end

  p_valid_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_valid_o |=> !frame_valid_o);

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ch_o) |-> frame_valid_o);

  p_valid_err_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(frame_valid_o && frame_err_o));

  p_err_after_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_err_o |-> ($past(fsync_i) && !$past(fsync_i, 2)));

  p_zero_fill_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_valid_o |-> (low_bad == '0));
endmodule

bind dsp_tdm_rx dsp_tdm_rx_chk #(.NUM_SLOTS(NUM_SLOTS), .DATA_W(DATA_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .wlen_i        (wlen_i),
  .fsync_i       (fsync_i),
  .ch_o          (ch_o),
  .frame_valid_o (frame_valid_o),
  .frame_err_o   (frame_err_o)
);

// File: tb/sim_dsp_tdm_rx.sv
`timescale 1ns/1ps
module sim_dsp_tdm_rx;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   wlen = 2'd0;
  logic         fsync = 1'b0;
  logic         sdata = 1'b0;
  logic [255:0] ch;
  logic         vld;
  logic         err;

  int checks = 0;
  int errors = 0;
  int vld_cnt, err_cnt, err_pos;
  logic vld_end;
  logic [31:0] wa [8];
  logic [31:0] wb [8];
  logic [31:0] wc [8];

  always #4 clk = ~clk;

  dsp_tdm_rx u0 (
    .clk_i(clk), .rst_ni(rst_n), .wlen_i(wlen), .fsync_i(fsync), .sdata_i(sdata),
    .ch_o(ch), .frame_valid_o(vld), .frame_err_o(err)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] code(input int wl);
    case (wl)
      16: return 2'd0;
      20: return 2'd1;
      24: return 2'd2;
      default: return 2'd3;
    endcase
  endfunction

  function automatic logic [31:0] just(input logic [31:0] w, input int wl);
    logic [31:0] m = (wl == 32) ? 32'hFFFF_FFFF : ((32'd1 << wl) - 32'd1);
    return (w & m) << (32 - wl);
  endfunction

  task automatic fill(output logic [31:0] w [8], input logic [31:0] seed);
    for (int k = 0; k < 8; k++) w[k] = seed ^ (32'h1357_9BDF * (k + 1)) ^ (32'h8000_0001 << k);
  endtask

  task automatic run_frame(input logic [31:0] w [8], input int wl, input int fs_w, input int nbits);
    vld_cnt = 0; err_cnt = 0; err_pos = -1;
    @(negedge clk);
    wlen = code(wl); fsync = 1'b1; sdata = 1'b0;
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk);
      if (err) begin err_cnt++; if (err_pos < 0) err_pos = i; end
      if (vld) vld_cnt++;
      fsync = (i + 1 < fs_w);
      sdata = w[i / wl][wl - 1 - (i % wl)];
    end
    @(negedge clk);
    if (err) err_cnt++;
    if (vld) vld_cnt++;
    vld_end = vld;
    fsync = 1'b0; sdata = 1'b0;
  endtask

  task automatic check_slots(input logic [31:0] w [8], input int wl, input string req);
    for (int k = 0; k < 8; k++)
      chk(ch[k*32 +: 32] == just(w[k], wl), req, ch[k*32 +: 32], just(w[k], wl));
  endtask

  task automatic t_reset;
    fsync = 1'b1;
    repeat (3) @(negedge clk);
    chk(ch == '0, "R9 ch reset", ch[31:0], 32'h0);
    chk(!vld && !err, "R9 strobes reset", {30'd0, vld, err}, 32'h0);
    rst_n = 1'b1;
    wlen = 2'd0; vld_cnt = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (vld || err) vld_cnt++;
      fsync = (i < 4);
      sdata = i[0] ^ i[2];
    end
    chk(vld_cnt == 0, "R9 high sync at release no frame", vld_cnt, 0);
    chk(ch == '0, "R9 ch untouched", ch[31:0], 32'h0);
  endtask

  task automatic t_len(input int wl, input logic [31:0] seed);
    fill(wa, seed);
    run_frame(wa, wl, 1, 8 * wl);
    chk(vld_end == 1'b1, "R6 valid after last LSB", vld_end, 1);
    chk(vld_cnt == 1, "R6 single strobe", vld_cnt, 1);
    chk(err_cnt == 0, "R8 no error on full frame", err_cnt, 0);
    check_slots(wa, wl, (wl == 32) ? "R1 R2 R3 R4 slot value" : "R2 R5 slot value");
  endtask

  task automatic t_wide_sync;
    fill(wa, 32'h0F1E_2D3C);
    run_frame(wa, 24, 10, 8 * 24);
    chk(vld_cnt == 1 && vld_end, "R10 wide sync one frame", vld_cnt, 1);
    chk(err_cnt == 0, "R10 wide sync no error", err_cnt, 0);
    check_slots(wa, 24, "R10 slot value");
  endtask

  task automatic t_tail;
    fill(wa, 32'h5A5A_3C3C);
    run_frame(wa, 20, 1, 8 * 20);
    vld_cnt = 0; err_cnt = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (vld) vld_cnt++;
      if (err) err_cnt++;
      sdata = ~sdata ^ i[1];
    end
    chk(vld_cnt == 0 && err_cnt == 0, "R7 tail no strobe", vld_cnt + err_cnt, 0);
    check_slots(wa, 20, "R7 tail ch held");
  endtask

  task automatic t_early_sync;
    fill(wa, 32'hC001_D00D);
    fill(wb, 32'h7777_1111);
    fill(wc, 32'h2468_ACE0);
    run_frame(wa, 16, 1, 8 * 16);
    run_frame(wb, 16, 1, 40);
    chk(vld_cnt == 0, "R8 partial no valid", vld_cnt, 0);
    check_slots(wa, 16, "R8 partial discarded");
    run_frame(wc, 16, 1, 8 * 16);
    chk(err_cnt == 1, "R8 one error pulse", err_cnt, 1);
    chk(err_pos == 0, "R8 error cycle after rise", err_pos, 0);
    chk(vld_cnt == 1 && vld_end, "R8 restart frame valid", vld_cnt, 1);
    check_slots(wc, 16, "R8 restart slot value");
  endtask

  initial begin
    t_reset();
    t_len(32, 32'hDEAD_BEEF);
    t_len(16, 32'h1234_5678);
    t_len(20, 32'h9ABC_DEF0);
    t_len(24, 32'h0BAD_F00D);
    t_wide_sync();
    t_tail();
    t_early_sync();
    t_len(32, 32'h3141_5926);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule